// File: doc/BRIEF.md
# Stereo PWM Audio DAC Core

The core turns 16-bit PCM audio into two one-bit pulse-width-modulated streams, one per channel. Analog filtering outside the chip recovers the audio. Software, or a streaming engine, writes into a small register window. One word address holds the sample data. The other holds a control word. The control word sets the modulator resolution, the pulse alignment, how many PWM periods each sample lasts, whether samples are signed, a pre-shift, channel swapping and mono packing.

A one-entry holding register sits between the write port and the modulator. The `data_req` output is high while the core runs and the holding register is empty, and a streaming source uses it for flow control. A sample leaves the holding register only at the end of the last PWM period of the current sample. If the register is still empty at that point, the core keeps playing the old sample and raises `underrun`.

The output sample rate is the core clock divided by the period length times the repeat count. For example, a 12.288 MHz clock with the 256-cycle period and one repetition gives 48 kHz.

Top module: `pwm_audio_dac`

## Requirements
- R1: After reset, `pwm_left`, `pwm_right`, `data_req` and `underrun` are low, and every control field is zero, so the modulator is stopped.
- R2: A write to byte offset 0 loads the sample holding register. A write to byte offset 4 loads the control word, which has these fields:
  - bit 0: run
  - bit 1: resolution
  - bits 3:2: alignment
  - bits 12:4: repeat count minus one
  - bit 13: channel swap
  - bit 14: sign conversion
  - bits 17:15: pre-shift
  - bit 18: mono packing
- R3: Writing 0 to bit 0 drives `data_req` low on the next cycle and both PWM outputs low one cycle later. Writing 1 again resumes output with the other control fields unchanged.
- R4: Bit 1 = 0 gives a 256-cycle PWM period and a duty value equal to sample bits 15:8. Bit 1 = 1 gives a 1024-cycle period and a duty value equal to bits 15:6.
- R5: Alignment code 0 (left) drives the output high for exactly the first duty-value cycles of each period. A duty value of 0 keeps the output low for the whole period.
- R6: Alignment code 1 (right) drives the output high for exactly the last duty-value cycles of each period.
- R7: Alignment code 2 (centre) drives the output high for 2*floor(duty/2) cycles, placed symmetrically about the middle of the period.
- R8: Each sample is played for (bits 12:4)+1 whole periods, 1 to 512. The next sample is taken only at the end of the last of those periods.
- R9: With bit 14 set, the sample MSB is inverted before the duty value is taken, so two's-complement input becomes offset binary. With bit 14 clear, the sample is used unchanged.
- R10: Bits 17:15 shift the (converted) sample left by 0 to 7 places. Zeros fill from the right and the result is truncated to 16 bits before the duty value is taken.
- R11: With bit 13 set, `pwm_left` plays the right-channel sample and `pwm_right` plays the left-channel sample.
- R12: With bit 18 clear, a data write carries the left sample in bits 15:0 and the right sample in bits 31:16. With bit 18 set, bits 15:0 go to both channels.
- R13: `data_req` equals run AND holding-register-empty. A data write makes the register full on the next cycle, and taking the sample empties it.
- R14: When a sample is due and the holding register is empty, `underrun` goes high and the previous sample repeats. `underrun` goes low again at the next sample boundary that finds a sample waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, also the PWM counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | ADDR_W (3) | Byte offset of the write |
| wr_data | input | DATA_W (32) | Write data |
| pwm_left | output | 1 | Left-channel PWM stream |
| pwm_right | output | 1 | Right-channel PWM stream |
| data_req | output | 1 | Holding register empty while running |
| underrun | output | 1 | Last sample boundary found no sample waiting |

## Verification
The bench builds the core with its default parameters: 16-bit samples, 8-bit and 10-bit resolutions, and a 9-bit repeat field. These defaults give both period lengths, the full 0 to 7 pre-shift range and repeat counts beyond one. The short 256-cycle period keeps each captured window small, so every alignment mode can be compared cycle by cycle against the expected waveform. The bench uses the rising edge of `data_req` to find the period in which a freshly written sample first plays. Timing the gaps between those edges with back-to-back writes exposes the repeat count.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

  localparam int CTRL_W  = 19;
  localparam int REP_W   = 9;
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_RIGHT  = 2'd1,
    ALIGN_CENTRE = 2'd2
  } align_e;

  // Field order matches the control word bit positions, MSB first.
  typedef struct packed {
    logic               mono;
    logic [SHIFT_W-1:0] pre_shift;
    logic               msb_flip;
    logic               swap_lr;
    logic [REP_W-1:0]   rep_m1;
    logic [1:0]         align;
    logic               hi_res;
    logic               run;
  } ctrl_t;

endpackage

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs
  import pwm_dac_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fetch,
  output ctrl_t             ctrl,
  output logic [SMP_W-1:0]  act_l,
  output logic [SMP_W-1:0]  act_r,
  output logic              hold_full,
  output logic              underrun
);

  localparam logic [ADDR_W-1:0] SMP_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(4);

  ctrl_t            ctrl_q, ctrl_nxt;
  logic [SMP_W-1:0] hold_l_q, hold_r_q, hold_l_nxt, hold_r_nxt;
  logic [SMP_W-1:0] act_l_q, act_r_q, act_l_nxt, act_r_nxt;
  logic             full_q, full_nxt;
  logic             urun_q, urun_nxt;
  logic             ctrl_we, smp_we, take;

  assign ctrl_we = wr_en && (wr_addr == CTRL_OFS);
  assign smp_we  = wr_en && (wr_addr == SMP_OFS);
  assign take    = fetch && full_q;

  always_comb begin
    ctrl_nxt   = ctrl_q;
    hold_l_nxt = hold_l_q;
    hold_r_nxt = hold_r_q;
    act_l_nxt  = act_l_q;
    act_r_nxt  = act_r_q;
    full_nxt   = full_q;
    urun_nxt   = urun_q;
    if (ctrl_we) ctrl_nxt = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (take) begin
      act_l_nxt = hold_l_q;
      act_r_nxt = hold_r_q;
      full_nxt  = 1'b0;
    end
    if (smp_we) begin
      hold_l_nxt = wr_data[SMP_W-1:0];
      hold_r_nxt = ctrl_q.mono ? wr_data[SMP_W-1:0] : wr_data[2*SMP_W-1:SMP_W];
      full_nxt   = 1'b1;
    end
    if (fetch) urun_nxt = ~full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      act_l_q  <= '0;
      act_r_q  <= '0;
      full_q   <= 1'b0;
      urun_q   <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_nxt;
      if (smp_we) begin
        hold_l_q <= hold_l_nxt;
        hold_r_q <= hold_r_nxt;
      end
      if (take) begin
        act_l_q <= act_l_nxt;
        act_r_q <= act_r_nxt;
      end
      full_q <= full_nxt;
      urun_q <= urun_nxt;
    end
  end

  assign ctrl      = ctrl_q;
  assign act_l     = act_l_q;
  assign act_r     = act_r_q;
  assign hold_full = full_q;
  assign underrun  = urun_q;

endmodule

// File: rtl/pwm_dac_timebase.sv
module pwm_dac_timebase #(
  parameter int LO_RES = 8,
  parameter int HI_RES = 10,
  parameter int REP_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hi_res,
  input  logic [REP_W-1:0]  rep_m1,
  output logic [HI_RES-1:0] cnt,
  output logic              fetch
);

  localparam logic [HI_RES-1:0] LAST_LO = HI_RES'((1 << LO_RES) - 1);
  localparam logic [HI_RES-1:0] LAST_HI = HI_RES'((1 << HI_RES) - 1);

  logic [HI_RES-1:0] cnt_q, cnt_nxt, last_val;
  logic [REP_W-1:0]  rep_q, rep_nxt;
  logic              at_end, rep_done;

  assign last_val = hi_res ? LAST_HI : LAST_LO;
  // ">=" lets a resolution change mid-period wrap cleanly
  assign at_end   = (cnt_q >= last_val);
  assign rep_done = (rep_q >= rep_m1);

  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    rep_nxt = rep_q;
    if (!run) begin
      cnt_nxt = '0;
      rep_nxt = '0;
    end else if (at_end) begin
      cnt_nxt = '0;
      rep_nxt = rep_done ? '0 : rep_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rep_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      rep_q <= rep_nxt;
    end
  end

  assign cnt   = cnt_q;
  assign fetch = run && at_end && rep_done;

endmodule

// File: rtl/pwm_dac_chan.sv
module pwm_dac_chan
  import pwm_dac_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int LO_RES = 8,
  parameter int HI_RES = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SMP_W-1:0]   sample,
  input  logic               msb_flip,
  input  logic [SHIFT_W-1:0] pre_shift,
  input  logic               hi_res,
  input  logic [1:0]         align,
  input  logic [HI_RES-1:0]  cnt,
  output logic               pwm
);

  localparam int EW = HI_RES + 1;
  localparam logic [EW-1:0] PLEN_LO = EW'(1 << LO_RES);
  localparam logic [EW-1:0] PLEN_HI = EW'(1 << HI_RES);

  logic [SMP_W-1:0] conv, shifted;
  logic [EW-1:0]    duty, plen, half, cnt_e, tri_pos;
  logic             pwm_q, pwm_nxt;

  always_comb begin
    conv    = sample ^ {msb_flip, {(SMP_W-1){1'b0}}};
    shifted = conv << pre_shift;
    if (hi_res) duty = EW'(shifted[SMP_W-1 -: HI_RES]);
    else        duty = EW'(shifted[SMP_W-1 -: LO_RES]);
    plen    = hi_res ? PLEN_HI : PLEN_LO;
    half    = plen >> 1;
    cnt_e   = EW'(cnt);
    tri_pos = (cnt_e < half) ? cnt_e : (plen - 1'b1 - cnt_e);
    case (align_e'(align))
      ALIGN_RIGHT:  pwm_nxt = (cnt_e >= (plen - duty));
      ALIGN_CENTRE: pwm_nxt = (tri_pos >= (half - (duty >> 1)));
      default:      pwm_nxt = (cnt_e < duty);
    endcase
    pwm_nxt = pwm_nxt && run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_nxt;
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
  import pwm_dac_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int LO_RES = 8,
  parameter int HI_RES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_left,
  output logic              pwm_right,
  output logic              data_req,
  output logic              underrun
);

  localparam int NCH = 2;

  ctrl_t             ctrl;
  logic [SMP_W-1:0]  act_l, act_r;
  logic [SMP_W-1:0]  chan_smp [NCH];
  logic [NCH-1:0]    chan_pwm;
  logic [HI_RES-1:0] cnt;
  logic              fetch, hold_full;

  pwm_dac_regs #(.SMP_W(SMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fetch(fetch), .ctrl(ctrl), .act_l(act_l), .act_r(act_r),
    .hold_full(hold_full), .underrun(underrun)
  );

  pwm_dac_timebase #(.LO_RES(LO_RES), .HI_RES(HI_RES), .REP_W(REP_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .hi_res(ctrl.hi_res),
    .rep_m1(ctrl.rep_m1), .cnt(cnt), .fetch(fetch)
  );

  assign chan_smp[0] = ctrl.swap_lr ? act_r : act_l;
  assign chan_smp[1] = ctrl.swap_lr ? act_l : act_r;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_dac_chan #(.SMP_W(SMP_W), .LO_RES(LO_RES), .HI_RES(HI_RES)) u_chan (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .sample(chan_smp[g]),
      .msb_flip(ctrl.msb_flip), .pre_shift(ctrl.pre_shift), .hi_res(ctrl.hi_res),
      .align(ctrl.align), .cnt(cnt), .pwm(chan_pwm[g])
    );
  end

  assign pwm_left  = chan_pwm[0];
  assign pwm_right = chan_pwm[1];
  assign data_req  = ctrl.run && !hold_full;

endmodule

// File: rtl/pwm_dac_sva.sv
module pwm_dac_sva #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              pwm_left,
  input logic              pwm_right,
  input logic              data_req,
  input logic              underrun
);

  localparam logic [ADDR_W-1:0] SMP_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(4);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pwm_left && !pwm_right && !data_req && !underrun));

  assert_stop_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_OFS && !wr_data[0]) |=> !data_req);

  assert_stop_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_OFS && !wr_data[0]) ##1 !(wr_en && wr_addr == CTRL_OFS)
      |=> (!pwm_left && !pwm_right));

  assert_fill_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SMP_OFS) |=> !data_req);

  assert_req_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_req) |-> $past(wr_en));

  assert_urun_set_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(data_req));

  assert_urun_clr_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(underrun) |-> $past(!data_req));

endmodule

bind pwm_audio_dac pwm_dac_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_left(pwm_left), .pwm_right(pwm_right), .data_req(data_req), .underrun(underrun)
);

// File: tb/sim_pwm_audio_dac.sv
module sim_pwm_audio_dac;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic pwm_left, pwm_right, data_req, underrun;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  bit c_hi = 0; int c_align = 0; bit c_flip = 0; int c_shift = 0;
  bit c_swap = 0; bit c_mono = 0; int c_rep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  pwm_audio_dac u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_left(pwm_left), .pwm_right(pwm_right), .data_req(data_req), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input bit run);
    logic [31:0] w;
    w = '0;
    w[0] = run; w[1] = c_hi; w[3:2] = c_align[1:0]; w[12:4] = c_rep[8:0];
    w[13] = c_swap; w[14] = c_flip; w[17:15] = c_shift[2:0]; w[18] = c_mono;
    return w;
  endfunction

  function automatic int exp_duty(input logic [15:0] s);
    logic [15:0] c;
    c = s ^ {c_flip, 15'd0};
    c = c << c_shift;
    return c_hi ? int'(c[15:6]) : int'(c[15:8]);
  endfunction

  function automatic bit exp_bit(input int idx, input int d);
    int p, h, t;
    p = c_hi ? 1024 : 256;
    h = p / 2;
    t = (idx < h) ? idx : p - 1 - idx;
    case (c_align)
      1: return idx >= p - d;
      2: return t >= h - d / 2;
      default: return idx < d;
    endcase
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_req(input string req);
    int guard;
    guard = 0;
    while (!data_req && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, req, "data_req rise timeout", guard, 0);
  endtask

  // Writes a word, aligns on the sample boundary and compares one full period.
  task automatic measure(input logic [31:0] w, input string req);
    logic [15:0] sl, sr, tmp;
    int dl, dr, el, er, p;
    sl = w[15:0];
    sr = c_mono ? w[15:0] : w[31:16];
    if (c_swap) begin tmp = sl; sl = sr; sr = tmp; end
    dl = exp_duty(sl); dr = exp_duty(sr);
    p = c_hi ? 1024 : 256;
    el = 0; er = 0;
    wr(3'd0, w);
    wait_req(req);
    @(negedge clk);
    for (int i = 0; i < p; i++) begin
      if (pwm_left !== exp_bit(i, dl)) el++;
      if (pwm_right !== exp_bit(i, dr)) er++;
      @(negedge clk);
    end
    chk(el == 0, req, $sformatf("left waveform errors (duty %0d)", dl), el, 0);
    chk(er == 0, req, $sformatf("right waveform errors (duty %0d)", dr), er, 0);
  endtask

  task automatic count_ones(output int nl, output int nr);
    int p;
    p = c_hi ? 1024 : 256;
    nl = 0; nr = 0;
    for (int i = 0; i < p; i++) begin
      if (pwm_left) nl++;
      if (pwm_right) nr++;
      @(negedge clk);
    end
  endtask

  task automatic apply_ctrl();
    wr(3'd4, ctrl_word(1'b1));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int t0, t1, t2, nl, nr, guard;
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!pwm_left && !pwm_right, "R1", "pwm outputs after reset", pwm_left + pwm_right, 0);
    chk(!data_req, "R1", "data_req after reset", data_req, 0);
    chk(!underrun, "R1", "underrun after reset", underrun, 0);

    // R13 / R2: enabling with an empty holding register requests data
    c_hi = 0; c_align = 0;
    apply_ctrl();
    chk(data_req, "R13", "data_req once running and empty", data_req, 1);
    wr(3'd0, 32'h1111_2222);
    chk(!data_req, "R13", "data_req after sample write", data_req, 0);
    wait_req("R13");

    // R5 R12 R2 left, stereo packing
    measure(32'h4000_8000, "R5");
    measure(32'h00FF_0000, "R5");       // duty 0 on both channels
    measure(32'hFF00_0100, "R12");
    // R6 right alignment
    c_align = 1; apply_ctrl();
    measure(32'h1234_C000, "R6");
    // R7 centre alignment, odd duty
    c_align = 2; apply_ctrl();
    measure(32'h0300_4100, "R7");
    measure(32'hFFFF_8000, "R7");
    // R4 high resolution
    c_hi = 1; c_align = 0; apply_ctrl();
    measure(32'hFFC0_0040, "R4");
    // R4 period length: rising edges of a steady left-aligned pulse
    guard = 0;
    while (!(pwm_left == 0) && guard < 3000) begin @(negedge clk); guard++; end
    while (!(pwm_left == 1) && guard < 3000) begin @(negedge clk); guard++; end
    t0 = cyc;
    @(negedge clk);
    while (!(pwm_left == 0) && guard < 3000) begin @(negedge clk); guard++; end
    while (!(pwm_left == 1) && guard < 3000) begin @(negedge clk); guard++; end
    chk(cyc - t0 == 1024, "R4", "period in 10-bit mode", cyc - t0, 1024);
    // R9 sign conversion
    c_hi = 0; c_flip = 1; apply_ctrl();
    measure(32'hFFFF_0000, "R9");
    // R10 pre-shift
    c_flip = 0; c_shift = 3; apply_ctrl();
    measure(32'h1F00_0123, "R10");
    c_shift = 7; apply_ctrl();
    measure(32'h01FF_0003, "R10");
    // R11 swap
    c_shift = 0; c_swap = 1; apply_ctrl();
    measure(32'h2000_C000, "R11");
    // R12 mono packing
    c_swap = 0; c_mono = 1; apply_ctrl();
    measure(32'hAAAA_3000, "R12");
    c_mono = 0; apply_ctrl();

    // R14 underrun: no writes, last sample repeats
    measure(32'h6000_A000, "R14");
    repeat (600) @(negedge clk);
    chk(underrun, "R14", "underrun after missed sample", underrun, 1);
    chk(data_req, "R14", "data_req while starved", data_req, 1);
    count_ones(nl, nr);
    chk(nl == 160 && nr == 96, "R14", "held sample ones count left", nl, 160);
    chk(nr == 96, "R14", "held sample ones count right", nr, 96);
    wr(3'd0, 32'h1000_1000);
    wait_req("R14");
    chk(!underrun, "R14", "underrun after refill", underrun, 1'b0);

    // R8 repeat count 3: back-to-back writes, time the request edges
    c_rep = 2; apply_ctrl();
    wr(3'd0, 32'h5555_5555); wait_req("R8");
    t0 = cyc;
    wr(3'd0, 32'h6666_6666); @(negedge clk); wait_req("R8");
    t1 = cyc;
    wr(3'd0, 32'h7777_7777); @(negedge clk); wait_req("R8");
    t2 = cyc;
    chk(t1 - t0 == 768, "R8", "sample spacing with repeat 3", t1 - t0, 768);
    chk(t2 - t1 == 768, "R8", "second sample spacing", t2 - t1, 768);
    c_rep = 0; apply_ctrl();

    // R3 stop and resume
    c_align = 2; apply_ctrl();
    measure(32'h7000_9000, "R3");
    wr(3'd4, ctrl_word(1'b0));
    @(negedge clk);
    nl = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwm_left || pwm_right || data_req) nl++;
      @(negedge clk);
    end
    chk(nl == 0, "R3", "cycles with activity while stopped", nl, 0);
    apply_ctrl();
    measure(32'h7000_9000, "R3");

    // Random mix
    for (int k = 0; k < 20; k++) begin
      c_hi = $urandom_range(0, 1); c_align = $urandom_range(0, 2);
      c_flip = $urandom_range(0, 1); c_shift = $urandom_range(0, 7);
      c_swap = $urandom_range(0, 1); c_mono = $urandom_range(0, 1);
      apply_ctrl();
      w = $urandom;
      measure(w, "R4");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule